// File: doc/BRIEF.md
# Selector-Coded I2C Control Target

This block is an I2C target that holds the control settings of a two-channel power regulator. The device address comes first. After it, every data byte the controller writes names its destination register itself: the upper three bits form a selector code, and the lower five bits are the new settings. No separate subaddress byte is used. Some field positions hold diagnostics rather than settings. Writes to those positions are dropped, and reads return live status flags in their place.

A read begins when the controller sends the address with R/W set to 1. The block then returns its registers as a stream, one byte after another, in ascending order. Each ACK from the controller moves the stream on, and a NACK ends it. A power-good input gates the whole block: while it is low, the bus is ignored and every control field is held at zero. SDA is only ever pulled low through an output enable. SCL and SDA are sampled through synchronizers on the system clock.

Top module: `i2c_rs_target`

## Requirements
- R1: An address byte whose upper seven bits equal DEV_ADDR (default 7'h08) is ACKed by pulling SDA low during the 9th clock. Any other address is not ACKed, and the block then ignores every clock until the next START.
- R2: A written data byte with selector bits [7:5] equal to 100, 101, 110 or 111 updates register 0, 1, 2 or 3 respectively. That register's writable bits take their values from data bits [4:0]. Register k appears on ctrl_o[5k+4:5k]. All registers are zero after reset.
- R3: Read-only positions are register 0 bits 4:3, register 1 bits 4:3, register 2 bit 4 and register 3 bits 4:3. A write never sets these positions, and ctrl_o always shows zero there.
- R4: A data byte with selector 000, 001, 010 or 011 is ACKed and then discarded, with no change to ctrl_o.
- R5: After an ACKed read address, the block sends bytes MSB first, one bit per SCL low phase. Each byte is the register's selector code in bits [7:5] followed by its five field bits.
- R6: The first byte of a read is register 0. Each controller ACK moves to the next register in ascending order, and the order wraps from register 3 back to register 0.
- R7: In read bytes, the read-only positions carry status_i as follows: [0] is register 0 bit 4, [1] is register 0 bit 3, [2] is register 1 bit 4, [3] is register 1 bit 3, [4] is register 2 bit 4, [5] is register 3 bit 4 and [6] is register 3 bit 3. The flags are sampled at the SCL fall that ends the ACK clock before the byte, and later changes do not affect a byte already loaded.
- R8: A NACK from the controller ends the read. SDA is released and stays released until the next START.
- R9: While pwr_good is low, no byte is ACKed, SDA is never pulled low, and ctrl_o is held at zero.
- R10: A repeated START or a STOP that arrives partway through a data byte discards the partial byte.
- R11: SDA is never driven high. The pull-down enable is only asserted while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good | input | 1 | Supply-good level; low silences the bus side and clears the fields |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire (wired-AND result) |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| status_i | input | 7 | Diagnostic flags merged into read bytes |
| ctrl_o | output | 20 | Writable control fields, five bits per register |

## Verification
The bench writes ones into every read-only position. A design that let those writes through would show them on ctrl_o, and the reference comparison made every clock would catch it. Read streams run past the last register, so an off-by-one pointer or a missing wrap shows up as a wrong selector code in the fifth or sixth byte. Status flags are changed in the middle of a byte: a design that merged them live, rather than when the byte is loaded, would corrupt the byte's later bits. Further sequences cut write bytes short with a repeated START and with a STOP, send an address for a different device, and drop pwr_good. A design that stored partial bytes, answered the wrong address or kept state through a power-good drop would then show a wrong field or a stray ACK.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_RD,
      ST_RD_ACK
   } link_state_t;
endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);
   logic [STAGES-1:0] pipe;
   logic              last;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_rs_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe <= {STAGES{RST_VAL}};
         last <= RST_VAL;
      end else begin
         pipe <= {pipe[STAGES-2:0], d_i};
         last <= pipe[STAGES-1];
      end
   end

   assign level_o = pipe[STAGES-1];
   assign rise_o  = pipe[STAGES-1] & ~last;
   assign fall_o  = ~pipe[STAGES-1] & last;
endmodule

// File: rtl/i2c_rs_regs.sv
module i2c_rs_regs #(
   parameter int                     NREG      = 4,
   parameter int                     SEL_W     = 3,
   parameter int                     FIELD_W   = 5,
   parameter int                     BASE_CODE = 4,
   parameter int                     STAT_W    = 7,
   parameter logic [NREG*FIELD_W-1:0] RO_MASK  = {5'b11000, 5'b10000, 5'b11000, 5'b11000},
   localparam int                    PTR_W     = $clog2(NREG)
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                pwr_good,
   input  logic                                wr_en,
   input  logic [i2c_rs_pkg::BYTE_W-1:0]       wr_byte,
   input  logic [PTR_W-1:0]                    rd_ptr,
   input  logic [STAT_W-1:0]                   status_i,
   output logic [NREG*FIELD_W-1:0]             ctrl_o,
   output logic [i2c_rs_pkg::BYTE_W-1:0]       rd_byte
);
   logic [FIELD_W-1:0] view_arr [NREG];

   function automatic int stat_index(input int k, input int b);
      int n = 0;
      for (int j = 0; j < NREG*FIELD_W; j++) begin
         if (RO_MASK[j] && ((j / FIELD_W < k) || ((j / FIELD_W == k) && (j % FIELD_W > b))))
            n++;
      end
      return n;
   endfunction

   generate
      if (SEL_W + FIELD_W != i2c_rs_pkg::BYTE_W) begin : g_bad_split
         $error("i2c_rs_regs: selector plus field must fill one byte");
      end
      if (BASE_CODE + NREG > (1 << SEL_W)) begin : g_bad_codes
         $error("i2c_rs_regs: register codes exceed selector range");
      end
      if ($countones(RO_MASK) != STAT_W) begin : g_bad_stat
         $error("i2c_rs_regs: STAT_W must equal the read-only bit count");
      end

      for (genvar k = 0; k < NREG; k++) begin : g_reg
         localparam logic [FIELD_W-1:0] ROM = RO_MASK[k*FIELD_W +: FIELD_W];
         logic [FIELD_W-1:0] field;
         logic               hit;

         assign hit = wr_en && (wr_byte[i2c_rs_pkg::BYTE_W-1 -: SEL_W] == SEL_W'(BASE_CODE + k));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        field <= '0;
            else if (!pwr_good) field <= '0;
            else if (hit)      field <= wr_byte[FIELD_W-1:0] & ~ROM;
         end

         assign ctrl_o[k*FIELD_W +: FIELD_W] = field;

         for (genvar b = 0; b < FIELD_W; b++) begin : g_bit
            if (ROM[b]) begin : g_stat
               assign view_arr[k][b] = status_i[stat_index(k, b)];
            end else begin : g_ctl
               assign view_arr[k][b] = field[b];
            end
         end
      end
   endgenerate

   assign rd_byte = {SEL_W'(BASE_CODE) + SEL_W'(rd_ptr), view_arr[rd_ptr]};

   // R4: a byte whose selector maps to no register leaves every field unchanged
   assert_unmapped_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && pwr_good && ((int'(wr_byte[i2c_rs_pkg::BYTE_W-1 -: SEL_W]) < BASE_CODE) ||
                             (int'(wr_byte[i2c_rs_pkg::BYTE_W-1 -: SEL_W]) >= BASE_CODE + NREG)))
      |=> ($stable(ctrl_o) || !pwr_good));

   // R9: a low supply-good level clears every field by the next cycle
   assert_pg_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good |=> (ctrl_o == '0));
endmodule

// File: rtl/i2c_rs_link.sv
module i2c_rs_link #(
   parameter logic [6:0] DEV_ADDR = 7'h08,
   parameter int         NREG     = 4,
   localparam int        PTR_W    = $clog2(NREG)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          pwr_good,
   input  logic                          scl,
   input  logic                          scl_rise,
   input  logic                          scl_fall,
   input  logic                          sda,
   input  logic                          bus_start,
   input  logic                          bus_stop,
   input  logic [i2c_rs_pkg::BYTE_W-1:0] rd_byte,
   output logic [PTR_W-1:0]              rd_ptr,
   output logic                          wr_en,
   output logic [i2c_rs_pkg::BYTE_W-1:0] wr_byte,
   output logic                          sda_oe
);
   import i2c_rs_pkg::*;

   link_state_t       state;
   logic [BYTE_W-1:0] sh;
   logic [3:0]        cnt;
   logic              rw;
   logic              ack;

   generate
      if (NREG < 2) begin : g_bad_nreg
         $error("i2c_rs_link: NREG must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         sh     <= '0;
         cnt    <= '0;
         rw     <= 1'b0;
         ack    <= 1'b0;
         rd_ptr <= '0;
         wr_en  <= 1'b0;
         sda_oe <= 1'b0;
      end else if (!pwr_good) begin
         state  <= ST_IDLE;
         wr_en  <= 1'b0;
         sda_oe <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         if (bus_start) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else if (bus_stop) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               ST_ADDR, ST_WR: begin
                  if (scl_rise && cnt != 4'd8) begin
                     sh  <= {sh[BYTE_W-2:0], sda};
                     cnt <= cnt + 4'd1;
                  end else if (scl_fall && cnt == 4'd8) begin
                     if (state == ST_WR) begin
                        wr_en  <= 1'b1;
                        sda_oe <= 1'b1;
                        state  <= ST_WR_ACK;
                     end else if (sh[7:1] == DEV_ADDR) begin
                        rw     <= sh[0];
                        rd_ptr <= '0;
                        sda_oe <= 1'b1;
                        state  <= ST_ADDR_ACK;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (rw) begin
                        sh     <= rd_byte;
                        sda_oe <= ~rd_byte[BYTE_W-1];
                        state  <= ST_RD;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_WR;
                     end
                  end
               end
               ST_WR_ACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     cnt    <= '0;
                     state  <= ST_WR;
                  end
               end
               ST_RD: begin
                  if (scl_fall) begin
                     if (cnt == 4'd7) begin
                        sda_oe <= 1'b0;
                        state  <= ST_RD_ACK;
                     end else begin
                        sh     <= {sh[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~sh[BYTE_W-2];
                        cnt    <= cnt + 4'd1;
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise) begin
                     ack <= ~sda;
                     if (!sda)
                        rd_ptr <= (rd_ptr == PTR_W'(NREG-1)) ? '0 : rd_ptr + 1'b1;
                  end else if (scl_fall) begin
                     if (ack) begin
                        sh     <= rd_byte;
                        sda_oe <= ~rd_byte[BYTE_W-1];
                        cnt    <= '0;
                        state  <= ST_RD;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign wr_byte = sh;

   // R9: no pull-down while the supply is not good
   assert_pg_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good |=> !sda_oe);

   // R11: the pull-down only switches on while the bus clock is low
   assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl);

   // R8: SDA is released while the controller answers a read byte
   assert_rd_ack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RD_ACK) |-> !sda_oe);
endmodule

// File: rtl/i2c_rs_target.sv
module i2c_rs_target #(
   parameter logic [6:0]             DEV_ADDR  = 7'h08,
   parameter int                     NREG      = 4,
   parameter int                     SEL_W     = 3,
   parameter int                     FIELD_W   = 5,
   parameter int                     BASE_CODE = 4,
   parameter int                     STAT_W    = 7,
   parameter logic [NREG*FIELD_W-1:0] RO_MASK  = {5'b11000, 5'b10000, 5'b11000, 5'b11000},
   parameter int                     SYNC_STAGES = 2,
   localparam int                    PTR_W     = $clog2(NREG)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    pwr_good,
   input  logic                    scl_i,
   input  logic                    sda_i,
   output logic                    sda_oe_o,
   input  logic [STAT_W-1:0]       status_i,
   output logic [NREG*FIELD_W-1:0] ctrl_o
);
   logic scl_lvl, scl_rise, scl_fall;
   logic sda_lvl, sda_rise, sda_fall;
   logic bus_start, bus_stop;
   logic wr_en;
   logic [i2c_rs_pkg::BYTE_W-1:0] wr_byte, rd_byte;
   logic [PTR_W-1:0] rd_ptr;

   i2c_rs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d_i(scl_i),
      .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

   i2c_rs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d_i(sda_i),
      .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

   assign bus_start = scl_lvl & sda_fall;
   assign bus_stop  = scl_lvl & sda_rise;

   i2c_rs_link #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_link (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
      .scl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall), .sda(sda_lvl),
      .bus_start(bus_start), .bus_stop(bus_stop),
      .rd_byte(rd_byte), .rd_ptr(rd_ptr),
      .wr_en(wr_en), .wr_byte(wr_byte), .sda_oe(sda_oe_o));

   i2c_rs_regs #(.NREG(NREG), .SEL_W(SEL_W), .FIELD_W(FIELD_W), .BASE_CODE(BASE_CODE),
                 .STAT_W(STAT_W), .RO_MASK(RO_MASK)) u_regs (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
      .wr_en(wr_en), .wr_byte(wr_byte), .rd_ptr(rd_ptr), .status_i(status_i),
      .ctrl_o(ctrl_o), .rd_byte(rd_byte));
endmodule

// File: tb/i2c_rs_target_bench.sv
module i2c_rs_target_bench;
   localparam int CLK_PERIOD = 10;
   localparam int Q          = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pwr_good = 1'b1;
   logic        tb_scl = 1'b1;
   logic        tb_sda = 1'b1;
   logic [6:0]  status = '0;
   logic        sda_oe;
   logic [19:0] ctrl;
   logic        sda_bus;

   int   checks = 0;
   int   errors = 0;
   logic cmp_ctrl = 1'b0;
   logic prev_oe = 1'b0;
   logic [19:0] exp_ctrl = '0;
   logic [7:0]  exp_q [$];

   assign sda_bus = tb_sda & ~sda_oe;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_rs_target u_i2c_rs_target (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
      .scl_i(tb_scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
      .status_i(status), .ctrl_o(ctrl));

   task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // per-clock reference comparison (R2 R3 R9) and open-drain timing monitor (R11)
   always @(negedge clk) begin
      if (rst_n && cmp_ctrl)
         check(ctrl === exp_ctrl, "R2 ctrl_o vs model", 32'(ctrl), 32'(exp_ctrl));
      if (rst_n && sda_oe && !prev_oe)
         check(tb_scl == 1'b0, "R11 pull-down rose with SCL high", 32'(tb_scl), 32'd0);
      prev_oe = sda_oe;
   end

   function automatic logic [7:0] model_byte(input int k, input logic [6:0] s);
      case (k)
         0:       return {3'b100, s[0], s[1], exp_ctrl[2:0]};
         1:       return {3'b101, s[2], s[3], exp_ctrl[7:5]};
         2:       return {3'b110, s[4], exp_ctrl[13:10]};
         default: return {3'b111, s[5], s[6], exp_ctrl[17:15]};
      endcase
   endfunction

   task automatic model_write(input logic [7:0] d);
      case (d[7:5])
         3'b100: exp_ctrl[4:0]   = {2'b00, d[2:0]};
         3'b101: exp_ctrl[9:5]   = {2'b00, d[2:0]};
         3'b110: exp_ctrl[14:10] = {1'b0, d[3:0]};
         3'b111: exp_ctrl[19:15] = {2'b00, d[2:0]};
         default: ;   // R4: unmapped codes are dropped
      endcase
   endtask

   task automatic wait_q();
      repeat (Q) @(negedge clk);
   endtask

   task automatic i2c_start();
      tb_sda = 1'b1; wait_q();
      tb_scl = 1'b1; wait_q();
      tb_sda = 1'b0; wait_q();
      tb_scl = 1'b0; wait_q();
   endtask

   task automatic i2c_stop();
      tb_sda = 1'b0; wait_q();
      tb_scl = 1'b1; wait_q();
      tb_sda = 1'b1; wait_q();
   endtask

   task automatic write_bit(input logic b);
      tb_sda = b; wait_q();
      tb_scl = 1'b1; wait_q(); wait_q();
      tb_scl = 1'b0; wait_q();
   endtask

   task automatic read_bit(output logic b);
      tb_sda = 1'b1; wait_q();
      tb_scl = 1'b1; wait_q();
      b = sda_bus; wait_q();
      tb_scl = 1'b0; wait_q();
   endtask

   task automatic send_byte(input logic [7:0] d, input logic store, output logic acked);
      logic a;
      if (store) cmp_ctrl = 1'b0;
      for (int i = 7; i >= 0; i--) write_bit(d[i]);
      read_bit(a);
      acked = ~a;
      if (store) begin
         model_write(d);
         cmp_ctrl = 1'b1;
      end
   endtask

   task automatic recv_byte(input logic give_ack, input logic chg, input logic [6:0] nxt,
                            output logic [7:0] d);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         read_bit(b);
         d[i] = b;
         if (chg && i == 7) status = nxt;
      end
      write_bit(~give_ack);
   endtask

   initial begin
      logic       acked;
      logic [7:0] got;
      logic       b;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(sda_oe == 1'b0, "R11 reset: SDA released", 32'(sda_oe), 32'd0);
      check(ctrl == '0, "R2 reset: fields zero", 32'(ctrl), 32'd0);
      cmp_ctrl = 1'b1;

      // R1 R2 R3 R4: write every register with ones in read-only positions
      i2c_start();
      send_byte({7'h08, 1'b0}, 1'b0, acked);
      check(acked, "R1 write address ACK", 32'(acked), 32'd1);
      send_byte(8'h9F, 1'b1, acked);
      check(acked, "R2 reg0 write ACK", 32'(acked), 32'd1);
      send_byte(8'hB5, 1'b1, acked);
      send_byte(8'hDA, 1'b1, acked);
      send_byte(8'hF9, 1'b1, acked);
      send_byte(8'h3F, 1'b1, acked);
      check(acked, "R4 unmapped selector ACKed", 32'(acked), 32'd1);
      i2c_stop();
      check(ctrl == {5'b00001, 5'b01010, 5'b00101, 5'b00111}, "R3 read-only bits stay zero",
            32'(ctrl), 32'({5'b00001, 5'b01010, 5'b00101, 5'b00111}));

      // R5 R6 R8: stream six bytes, wrapping after register 3
      status = 7'b1010101;
      for (int k = 0; k < 6; k++) exp_q.push_back(model_byte(k % 4, status));
      i2c_start();
      send_byte({7'h08, 1'b1}, 1'b0, acked);
      check(acked, "R1 read address ACK", 32'(acked), 32'd1);
      for (int k = 0; k < 6; k++) begin
         logic [7:0] e;
         recv_byte(k != 5, 1'b0, 7'd0, got);
         e = exp_q.pop_front();
         check(got == e, (k < 4) ? "R5 read byte" : "R6 wrapped read byte", 32'(got), 32'(e));
      end
      @(negedge clk);
      check(sda_oe == 1'b0, "R8 released after NACK", 32'(sda_oe), 32'd0);
      for (int i = 0; i < 3; i++) begin
         read_bit(b);
         check(b == 1'b1, "R8 silent until START", 32'(b), 32'd1);
      end
      i2c_stop();

      // R7: flags sampled at byte load, not while the byte is shifting
      status = 7'b0000011;
      exp_q.push_back(model_byte(0, 7'b0000011));
      exp_q.push_back(model_byte(1, 7'b1111100));
      i2c_start();
      send_byte({7'h08, 1'b1}, 1'b0, acked);
      recv_byte(1'b1, 1'b1, 7'b1111100, got);
      check(got == exp_q[0], "R7 byte loaded before status change", 32'(got), 32'(exp_q[0]));
      void'(exp_q.pop_front());
      recv_byte(1'b0, 1'b0, 7'd0, got);
      check(got == exp_q[0], "R7 next byte sees new status", 32'(got), 32'(exp_q[0]));
      void'(exp_q.pop_front());
      i2c_stop();

      // R1: foreign address, then a data byte that must be ignored
      i2c_start();
      send_byte({7'h0A, 1'b0}, 1'b0, acked);
      check(!acked, "R1 foreign address not ACKed", 32'(acked), 32'd0);
      send_byte(8'hE0, 1'b0, acked);
      check(!acked, "R1 bytes ignored after mismatch", 32'(acked), 32'd0);
      i2c_stop();

      // R10: partial byte cut by repeated START, then by STOP
      i2c_start();
      send_byte({7'h08, 1'b0}, 1'b0, acked);
      for (int i = 7; i >= 3; i--) write_bit(8'h80 >> (7 - i) & 1);
      i2c_start();
      send_byte({7'h08, 1'b0}, 1'b0, acked);
      send_byte(8'hA0, 1'b1, acked);
      i2c_stop();
      check(ctrl[4:0] == 5'b00111, "R10 partial byte before repeated START dropped",
            32'(ctrl[4:0]), 32'd7);
      i2c_start();
      send_byte({7'h08, 1'b0}, 1'b0, acked);
      for (int i = 0; i < 4; i++) write_bit(i < 3);
      i2c_stop();
      check(ctrl[19:15] == 5'b00001, "R10 partial byte before STOP dropped",
            32'(ctrl[19:15]), 32'd1);

      // R9: supply not good
      cmp_ctrl = 1'b0;
      pwr_good = 1'b0;
      repeat (3) @(negedge clk);
      exp_ctrl = '0;
      cmp_ctrl = 1'b1;
      check(ctrl == '0, "R9 fields cleared", 32'(ctrl), 32'd0);
      i2c_start();
      send_byte({7'h08, 1'b0}, 1'b0, acked);
      check(!acked, "R9 no ACK while supply low", 32'(acked), 32'd0);
      send_byte(8'h9F, 1'b0, acked);
      check(!acked, "R9 data ignored while supply low", 32'(acked), 32'd0);
      i2c_stop();
      pwr_good = 1'b1;
      wait_q();
      i2c_start();
      send_byte({7'h08, 1'b0}, 1'b0, acked);
      check(acked, "R9 ACK again after supply good", 32'(acked), 32'd1);
      send_byte(8'hC3, 1'b1, acked);
      i2c_stop();
      check(ctrl[14:10] == 5'b00011, "R2 reg2 write after recovery", 32'(ctrl[14:10]), 32'd3);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule